// File: doc/BRIEF.md
# Flagged Barrel Shifter

This block shifts a 16-bit or 32-bit operand left, logically right or arithmetically right by an unsigned count, and reports carry, overflow, sign and zero flags alongside the result. The count is never reduced modulo the operand width. Any count at or past the active width moves every data bit out of the word: a left or logical right shift then gives zero, and an arithmetic right shift gives the sign fill. The flags follow fixed edge rules. Carry is the last bit moved out, but only for counts inside the word. Overflow is raised only for a single-place shift that changes the sign bit.

Inputs are sampled on every rising clock edge. The result and the four flags are registered and appear one cycle later. In 16-bit mode the upper half of the data input is ignored and the upper half of the result is zero. Selecting where the count comes from, a register or an immediate field, happens outside this block.

Top module: `shf_unit`

## Requirements
- R1: While `rst_n` is low, `res_o` and all four flag outputs are 0.
- R2: The result and flags for the inputs sampled at a rising edge appear right after that edge and hold until the next one, giving one cycle of latency.
- R3: With `dir_i`=0 (left), the result is the operand shifted left by `cnt_i` and cut to the active width (32 bits when `wide_i`=1, 16 when `wide_i`=0). A count at or above that width gives 0.
- R4: For a left shift with a count between 1 and width-1, `carry_o` equals operand bit (width - count). For a count at or above the width, `carry_o` is 0, so 1 shifted left by exactly the width gives carry 0.
- R5: With `dir_i`=1 and `arith_i`=0 (logical right), vacated top bits are zero. A count at or above the width gives 0.
- R6: For a right shift with a count between 1 and width-1, `carry_o` equals operand bit (count-1). For a count of 0 or a count at or above the width, `carry_o` is 0.
- R7: With `dir_i`=1 and `arith_i`=1, vacated top bits copy the operand's sign bit (bit width-1). A negative operand with a count at or above the width gives all ones at the active width. For a left shift, `arith_i` has no effect.
- R8: `ovf_o` is 1 only when the count equals 1 and the result's top bit at the active width differs from the operand's. For every other count it is 0.
- R9: `sign_o` is the result's bit (width-1), and `zero_o` is 1 exactly when the result is all zeros.
- R10: With `wide_i`=0, `data_i[31:16]` has no effect on any output and `res_o[31:16]` is 0.
- R11: A count of 0 returns the operand unchanged (at the active width), with `carry_o`=0, in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_i | input | 32 | Operand; only bits 15:0 used when `wide_i`=0 |
| cnt_i | input | 8 | Unsigned shift count, never wrapped |
| dir_i | input | 1 | 0 = shift left, 1 = shift right |
| arith_i | input | 1 | Right shifts only: 0 = logical, 1 = arithmetic |
| wide_i | input | 1 | 0 = 16-bit operation, 1 = 32-bit operation |
| res_o | output | 32 | Registered shift result |
| carry_o | output | 1 | Registered carry: last bit shifted out |
| ovf_o | output | 1 | Registered overflow: sign changed by a single-place shift |
| sign_o | output | 1 | Registered top bit of the result |
| zero_o | output | 1 | Registered all-zero indication |

## Verification
Each operation runs across every count from 0 to 34, plus 200 and 255. Six operands are used: a lone low bit, a lone top bit with a low bit, two alternating mixes, all ones, and a value whose sign flips on a one-place left shift. Together they separate the carry taps at either end of the word, the fill source of the arithmetic shift, the saturation point at the width and just past it, and the single count that may raise overflow. Directed cases cover 1 and 2 shifted left by 32 and 31, a count of 0, and 16-bit operations with junk in the upper data half, which separate the saturating count from a wrapped one and show the upper half has no effect.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int unsigned SHF_DATA_W = 32;
    localparam int unsigned SHF_HALF_W = 16;
    localparam int unsigned SHF_CNT_W  = 8;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic sign;
        logic zero;
    } shf_flags_t;

endpackage

// File: rtl/shf_count_clamp.sv
module shf_count_clamp #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned HALF_W = 16,
    parameter int unsigned CNT_W  = 8,
    localparam int unsigned CL_W  = $clog2(DATA_W + 1)
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wide_i,
    output logic [CL_W-1:0]  cnt_clamped_o,
    output logic             cnt_beyond_o,
    output logic             cnt_none_o,
    output logic             cnt_one_o
);

    logic [CNT_W-1:0] width_lim;

    always_comb begin
        width_lim = wide_i ? CNT_W'(DATA_W) : CNT_W'(HALF_W);
        if (cnt_i >= CNT_W'(DATA_W)) begin
            cnt_clamped_o = CL_W'(DATA_W);
        end else begin
            cnt_clamped_o = cnt_i[CL_W-1:0];
        end
        cnt_beyond_o = (cnt_i >= width_lim);
        cnt_none_o   = (cnt_i == '0);
        cnt_one_o    = (cnt_i == CNT_W'(1));
    end

endmodule

// File: rtl/shf_core.sv
module shf_core #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned HALF_W = 16,
    localparam int unsigned CL_W  = $clog2(DATA_W + 1),
    localparam int unsigned EXT_W = 2 * DATA_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CL_W-1:0]   cnt_i,
    input  logic              dir_i,
    input  logic              arith_i,
    input  logic              wide_i,
    output logic [DATA_W-1:0] res_o,
    output logic              raw_carry_o,
    output logic              src_sign_o
);

    logic              src_msb;
    logic              fill_bit;
    logic [DATA_W-1:0] left_op;
    logic [DATA_W-1:0] right_op;
    logic [EXT_W-1:0]  left_ext;
    logic [EXT_W-1:0]  right_ext;
    logic [DATA_W:0]   right_tap;
    logic [DATA_W-1:0] width_mask;
    logic [DATA_W-1:0] shifted;

    // Per-bit mask of the active width; upper half is disabled in narrow mode.
    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
        if (b < HALF_W) begin : g_low
            assign width_mask[b] = 1'b1;
        end else begin : g_high
            assign width_mask[b] = wide_i;
        end
    end

    always_comb begin
        src_msb  = wide_i ? data_i[DATA_W-1] : data_i[HALF_W-1];
        fill_bit = dir_i & arith_i & src_msb;

        left_op  = data_i & width_mask;
        right_op = (data_i & width_mask) | ({DATA_W{fill_bit}} & ~width_mask);

        left_ext  = {{DATA_W{1'b0}}, left_op} << cnt_i;
        right_ext = {{DATA_W{fill_bit}}, right_op} >> cnt_i;
        right_tap = {right_op, 1'b0} >> cnt_i;

        shifted = dir_i ? right_ext[DATA_W-1:0] : left_ext[DATA_W-1:0];
        res_o   = shifted & width_mask;

        if (dir_i) begin
            raw_carry_o = right_tap[0];
        end else begin
            raw_carry_o = wide_i ? left_ext[DATA_W] : left_ext[HALF_W];
        end
        src_sign_o = src_msb;
    end

endmodule

// File: rtl/shf_flag_gen.sv
module shf_flag_gen
    import shf_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned HALF_W = 16
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic              raw_carry_i,
    input  logic              src_sign_i,
    input  logic              wide_i,
    input  logic              cnt_beyond_i,
    input  logic              cnt_none_i,
    input  logic              cnt_one_i,
    output shf_flags_t        flags_o
);

    logic res_msb;

    always_comb begin
        res_msb       = wide_i ? res_i[DATA_W-1] : res_i[HALF_W-1];
        flags_o.carry = raw_carry_i & ~cnt_beyond_i & ~cnt_none_i;
        flags_o.ovf   = cnt_one_i & (res_msb ^ src_sign_i);
        flags_o.sign  = res_msb;
        flags_o.zero  = (res_i == '0);
    end

endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int unsigned DATA_W = SHF_DATA_W,
    parameter int unsigned HALF_W = SHF_HALF_W,
    parameter int unsigned CNT_W  = SHF_CNT_W,
    localparam int unsigned CL_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              dir_i,
    input  logic              arith_i,
    input  logic              wide_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o,
    output logic              ovf_o,
    output logic              sign_o,
    output logic              zero_o
);

    logic [CL_W-1:0]   cnt_clamped;
    logic              cnt_beyond;
    logic              cnt_none;
    logic              cnt_one;
    logic [DATA_W-1:0] res_comb;
    logic              raw_carry;
    logic              src_sign;
    shf_flags_t        flags_comb;
    shf_flags_t        flags_q;
    logic [DATA_W-1:0] res_q;

    shf_count_clamp #(
        .DATA_W (DATA_W),
        .HALF_W (HALF_W),
        .CNT_W  (CNT_W)
    ) clamp_i (
        .cnt_i         (cnt_i),
        .wide_i        (wide_i),
        .cnt_clamped_o (cnt_clamped),
        .cnt_beyond_o  (cnt_beyond),
        .cnt_none_o    (cnt_none),
        .cnt_one_o     (cnt_one)
    );

    shf_core #(
        .DATA_W (DATA_W),
        .HALF_W (HALF_W)
    ) core_i (
        .data_i      (data_i),
        .cnt_i       (cnt_clamped),
        .dir_i       (dir_i),
        .arith_i     (arith_i),
        .wide_i      (wide_i),
        .res_o       (res_comb),
        .raw_carry_o (raw_carry),
        .src_sign_o  (src_sign)
    );

    shf_flag_gen #(
        .DATA_W (DATA_W),
        .HALF_W (HALF_W)
    ) flags_i (
        .res_i        (res_comb),
        .raw_carry_i  (raw_carry),
        .src_sign_i   (src_sign),
        .wide_i       (wide_i),
        .cnt_beyond_i (cnt_beyond),
        .cnt_none_i   (cnt_none),
        .cnt_one_i    (cnt_one),
        .flags_o      (flags_comb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
        end else begin
            res_q   <= res_comb;
            flags_q <= flags_comb;
        end
    end

    always_comb begin
        res_o   = res_q;
        carry_o = flags_q.carry;
        ovf_o   = flags_q.ovf;
        sign_o  = flags_q.sign;
        zero_o  = flags_q.zero;
    end

endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned HALF_W = 16,
    parameter int unsigned CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] data_i,
    input logic [CNT_W-1:0]  cnt_i,
    input logic              dir_i,
    input logic              arith_i,
    input logic              wide_i,
    input logic [DATA_W-1:0] res_o,
    input logic              carry_o,
    input logic              ovf_o,
    input logic              sign_o,
    input logic              zero_o
);

    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (res_o == '0 && !carry_o && !ovf_o && !sign_o && !zero_o); // R1
        end
    end

    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wide_i)) |-> (res_o[DATA_W-1:HALF_W] == '0)); // R10

    AST_OVF_ONLY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ovf_o) |-> ($past(cnt_i) == CNT_W'(1))); // R8

    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (zero_o == (res_o == '0))); // R9

    AST_LEFT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(dir_i)
         && ($past(cnt_i) >= ($past(wide_i) ? CNT_W'(DATA_W) : CNT_W'(HALF_W))))
        |-> (!carry_o && res_o == '0)); // R4

    AST_ARITH_SAT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wide_i) && $past(dir_i) && $past(arith_i)
         && $past(data_i[DATA_W-1]) && ($past(cnt_i) >= CNT_W'(DATA_W)))
        |-> (res_o == '1)); // R7

    AST_CNT0_NOCARRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cnt_i) == '0) |-> !carry_o); // R11

endmodule

bind shf_unit shf_unit_chk #(
    .DATA_W (DATA_W),
    .HALF_W (HALF_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_i  (data_i),
    .cnt_i   (cnt_i),
    .dir_i   (dir_i),
    .arith_i (arith_i),
    .wide_i  (wide_i),
    .res_o   (res_o),
    .carry_o (carry_o),
    .ovf_o   (ovf_o),
    .sign_o  (sign_o),
    .zero_o  (zero_o)
);

// File: tb/shf_unit_tb_top.sv
`timescale 1ns/1ps
module shf_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] data_i = '0;
    logic [7:0]  cnt_i = '0;
    logic        dir_i = 1'b0;
    logic        arith_i = 1'b0;
    logic        wide_i = 1'b1;
    logic [31:0] res_o;
    logic        carry_o, ovf_o, sign_o, zero_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    shf_unit dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_i  (data_i),
        .cnt_i   (cnt_i),
        .dir_i   (dir_i),
        .arith_i (arith_i),
        .wide_i  (wide_i),
        .res_o   (res_o),
        .carry_o (carry_o),
        .ovf_o   (ovf_o),
        .sign_o  (sign_o),
        .zero_o  (zero_o)
    );

    // Bit-by-bit reference built from the requirements.
    task automatic model(input logic [31:0] d, input int cnt, input bit dir, input bit ar,
                         input bit wide, output logic [31:0] r, output bit c, output bit o,
                         output bit s, output bit z);
        int sz = wide ? 32 : 16;
        logic [31:0] msk = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        logic [31:0] src = d & msk;
        bit sb = src[sz-1];
        bit fill = dir && ar && sb;
        r = src;
        c = 1'b0;
        if (!dir) begin
            for (int i = 0; i < cnt && i < sz; i++) begin
                c = r[sz-1];
                r = (r << 1) & msk;
            end
            if (cnt >= sz) c = 1'b0;
        end else begin
            for (int i = 0; i < cnt && i < sz; i++) begin
                c = r[0];
                r = ((r >> 1) | ({31'b0, fill} << (sz - 1))) & msk;
            end
            if (cnt >= sz) c = 1'b0;
        end
        o = (cnt == 1) && (r[sz-1] != sb);
        s = r[sz-1];
        z = (r == 0);
    endtask

    task automatic cmp1(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Apply one vector, wait one edge, compare every output against the model.
    task automatic run_vec(input string rtag, input logic [31:0] d, input int cnt,
                           input bit dir, input bit ar, input bit wide);
        logic [31:0] er;
        bit ec, eo, es, ez;
        @(negedge clk);
        data_i = d; cnt_i = 8'(cnt); dir_i = dir; arith_i = ar; wide_i = wide;
        model(d, cnt, dir, ar, wide, er, ec, eo, es, ez);
        @(negedge clk);
        cmp1(rtag, "result", res_o, er);
        cmp1(dir ? "R6" : "R4", "carry", {31'b0, carry_o}, {31'b0, ec});
        cmp1("R8", "overflow", {31'b0, ovf_o}, {31'b0, eo});
        cmp1("R9", "sign", {31'b0, sign_o}, {31'b0, es});
        cmp1("R9", "zero", {31'b0, zero_o}, {31'b0, ez});
    endtask

    task automatic t_reset();
        data_i = 32'hFFFF_FFFF; cnt_i = 8'd1;
        repeat (3) @(negedge clk);
        cmp1("R1", "reset result", res_o, 32'h0);
        cmp1("R1", "reset flags", {28'b0, carry_o, ovf_o, sign_o, zero_o}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        run_vec("R2", 32'h0000_00F0, 4, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        data_i = 32'h0000_0003; cnt_i = 8'd1; dir_i = 1'b0;
        #1;
        cmp1("R2", "held before edge", res_o, 32'h0000_000F);
        @(negedge clk);
        cmp1("R2", "after one edge", res_o, 32'h0000_0006);
    endtask

    task automatic t_sweep();
        logic [31:0] pats [6] = '{32'h0000_0001, 32'h8000_0001, 32'hA5A5_3C3C,
                                  32'hFFFF_FFFF, 32'h4000_4000, 32'h5A5A_C3C3};
        for (int p = 0; p < 6; p++) begin
            for (int w = 0; w < 2; w++) begin
                for (int cnt = 0; cnt <= 36; cnt++) begin
                    int cc = (cnt == 35) ? 200 : (cnt == 36) ? 255 : cnt;
                    run_vec(w ? "R3" : "R10", pats[p], cc, 1'b0, 1'b0, w[0]);
                    run_vec("R3", pats[p], cc, 1'b0, 1'b1, w[0]);
                    run_vec("R5", pats[p], cc, 1'b1, 1'b0, w[0]);
                    run_vec("R7", pats[p], cc, 1'b1, 1'b1, w[0]);
                end
            end
        end
    endtask

    task automatic t_left_edges();
        run_vec("R4", 32'h0000_0001, 32, 1'b0, 1'b0, 1'b1);
        cmp1("R4", "1<<32 carry", {31'b0, carry_o}, 32'h0);
        run_vec("R4", 32'h0000_0002, 31, 1'b0, 1'b0, 1'b1);
        cmp1("R4", "2<<31 carry", {31'b0, carry_o}, 32'h1);
        run_vec("R4", 32'h0000_0001, 16, 1'b0, 1'b0, 1'b0);
        cmp1("R4", "narrow 1<<16 carry", {31'b0, carry_o}, 32'h0);
    endtask

    task automatic t_right_edges();
        run_vec("R6", 32'hFFFF_FFFF, 0, 1'b1, 1'b0, 1'b1);
        cmp1("R6", "count 0 carry", {31'b0, carry_o}, 32'h0);
        run_vec("R7", 32'h8000_0000, 40, 1'b1, 1'b1, 1'b1);
        cmp1("R7", "arith saturate", res_o, 32'hFFFF_FFFF);
        run_vec("R7", 32'h0000_8000, 20, 1'b1, 1'b1, 1'b0);
        cmp1("R7", "narrow arith saturate", res_o, 32'h0000_FFFF);
    endtask

    task automatic t_ovf_and_zero_cnt();
        run_vec("R8", 32'h4000_0000, 1, 1'b0, 1'b0, 1'b1);
        cmp1("R8", "left 1 sign flip", {31'b0, ovf_o}, 32'h1);
        run_vec("R8", 32'h4000_0000, 2, 1'b0, 1'b0, 1'b1);
        cmp1("R8", "count 2 no ovf", {31'b0, ovf_o}, 32'h0);
        run_vec("R11", 32'h1234_5678, 0, 1'b0, 1'b0, 1'b1);
        cmp1("R11", "count 0 identity", res_o, 32'h1234_5678);
        run_vec("R11", 32'h1234_5678, 0, 1'b1, 1'b1, 1'b0);
        cmp1("R11", "narrow count 0", res_o, 32'h0000_5678);
    endtask

    task automatic t_narrow_junk();
        run_vec("R10", 32'hDEAD_0001, 3, 1'b0, 1'b0, 1'b0);
        cmp1("R10", "junk upper left", res_o, 32'h0000_0008);
        run_vec("R10", 32'hFFFF_7FFF, 4, 1'b1, 1'b1, 1'b0);
        cmp1("R10", "junk upper arith", res_o, 32'h0000_07FF);
        run_vec("R10", 32'hFFFF_0000, 0, 1'b0, 1'b0, 1'b0);
        cmp1("R10", "junk upper zero flag", {31'b0, zero_o}, 32'h1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_latency();
        t_left_edges();
        t_right_edges();
        t_ovf_and_zero_cnt();
        t_narrow_junk();
        t_sweep();
        finish_run();
    end

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule